// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

This block is a 16-bit up-counter that runs in one of two modes. As a timer, it advances on an internal tick at one quarter of the system clock rate. As an event counter, it advances on qualified rising edges of an external input. A hidden 3-bit prescaler sits between the chosen source and the counter and divides it by 1, 2, 4 or 8. When the count wraps from 0xFFFF to 0x0000, a sticky overflow flag is set and also driven on `ovf_o`.

Software uses a byte-wide register port with write strobes and combinational reads. Address 0 holds the low count byte and address 1 the high count byte. Address 2 is the control register: bit 0 enable, bit 1 external-source select, bits 3:2 prescale code, bit 4 synchroniser bypass and bit 7 the overflow flag. Address 3 reads as zero. The count is read one byte at a time, so a carry between the two reads can give a torn 16-bit value.

The external input is always sampled by the system clock. In normal mode it passes through two flops. In bypass mode it uses only the first flop, which removes one cycle of latency. A rising edge is counted only after the counter has been armed by a falling edge. The arming is cleared by reset, by any count write, and whenever the block is disabled.

Top module: `evt_timer16`

## Requirements
- R1: After reset, the count bytes (addresses 0 and 1), the control register (address 2) and `ovf_o` all read 0.
- R2: With enable=1, source=0 and prescale code 0, the count advances by exactly one every four system clocks, so any 40-cycle window adds exactly 10.
- R3: Prescale code k (0..3) passes one increment for every 2^k source events, so a 64-cycle timer window adds exactly 16>>k.
- R4: While enable (control bit 0) is 0, the count holds its value.
- R5: In external mode without bypass, a qualified rising edge on `ext_i` first set up before clock edge k shows in the count after edge k+2 and not before.
- R6: If `ext_i` is already high when external counting is enabled, nothing is counted until `ext_i` has gone low and then high again.
- R7: A write to either count byte clears the prescaler to zero and disarms edge qualification. The next rising edge that has no falling edge before it is not counted.
- R8: If a count-byte write lands in the same cycle as an increment, the written byte wins and the increment is dropped.
- R9: A 0xFFFF to 0x0000 wrap sets the overflow flag (`ovf_o`, control bit 7). The flag stays set until a control write with bit 7 = 0 clears it. Writing bit 7 = 1 leaves it unchanged, and a wrap in the same cycle as a clear keeps it set.
- R10: With bypass (control bit 4) set, a qualified rising edge first set up before clock edge k shows in the count after edge k+1.
- R11: Address 0 reads the low count byte, address 1 the high count byte, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_i | input | 1 | External event input |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational) |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bound checker checks the local rules on every cycle:
- the count holds while the block is disabled;
- the count only steps by one unless it is written;
- the prescaler is cleared by count writes;
- a written byte wins over an increment;
- the overflow flag is set and kept correctly.

Only the bench scenarios can show the end-to-end behaviour:
- the tick rate in timer mode;
- the exact divide ratios;
- the input-to-count latency with and without bypass;
- the need for a falling edge after enable or a count write.

A behavioural reference model is also compared with the read data and the flag on every clock.

// File: rtl/evt_timer16_pkg.sv
package evt_timer16_pkg;
  localparam int CntW = 16;
  localparam int PscW = 2;

  typedef enum logic [1:0] {
    ADDR_CNT_LO = 2'd0,
    ADDR_CNT_HI = 2'd1,
    ADDR_CTRL   = 2'd2,
    ADDR_RSVD   = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic            bypass;
    logic [PscW-1:0] psc;
    logic            src_ext;
    logic            en;
  } ctrl_t;

  localparam int CtrlW   = $bits(ctrl_t);
  localparam int OvfBit  = 7;
endpackage

// File: rtl/evt_timer16_edge.sv
module evt_timer16_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  input  logic bypass_i,
  input  logic en_i,
  input  logic clr_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic sel, prev_q, armed_q, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= ext_i;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b0;
      else         sync_q[g] <= sync_q[g-1];
    end
  end

  assign sel  = bypass_i ? sync_q[0] : sync_q[SYNC_STAGES-1];
  assign fall = prev_q & ~sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q <= sel;
      // arming needs a falling edge after reset, count write or disable
      if (clr_i || !en_i) armed_q <= 1'b0;
      else if (fall)      armed_q <= 1'b1;
    end
  end

  assign rise_o = sel & ~prev_q & armed_q;
endmodule

// File: rtl/evt_timer16_psc.sv
module evt_timer16_psc #(
  parameter int PSC_W = 2,
  parameter int DIV_W = 2,
  localparam int PRE_W = (1 << PSC_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             src_ext_i,
  input  logic             edge_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic             clr_i,
  output logic             inc_o,
  output logic [PRE_W-1:0] pre_o
);
  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pre_q, mask;
  logic tick, ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  assign tick = &div_q;
  assign ev   = en_i & (src_ext_i ? edge_i : tick);

  always_comb mask = PRE_W'((32'd1 << psc_i) - 32'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (ev)     pre_q <= pre_q + 1'b1;
  end

  assign inc_o = ev & ((pre_q & mask) == mask);
  assign pre_o = pre_q;
endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
  import evt_timer16_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ext_i,
  input  logic       we_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       ovf_o
);
  localparam int PreW = (1 << PscW) - 1;

  ctrl_t           ctrl_q;
  logic [CntW-1:0] cnt_q;
  logic            ovf_q;
  logic            lo_wr, hi_wr, cnt_wr, ctrl_wr, ovf_clr;
  logic            edge_ok, inc;
  logic [PreW-1:0] pre;

  assign lo_wr   = we_i && (reg_addr_e'(addr_i) == ADDR_CNT_LO);
  assign hi_wr   = we_i && (reg_addr_e'(addr_i) == ADDR_CNT_HI);
  assign ctrl_wr = we_i && (reg_addr_e'(addr_i) == ADDR_CTRL);
  assign cnt_wr  = lo_wr | hi_wr;
  assign ovf_clr = ctrl_wr & ~wdata_i[OvfBit];

  evt_timer16_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ext_i    (ext_i),
    .bypass_i (ctrl_q.bypass),
    .en_i     (ctrl_q.en),
    .clr_i    (cnt_wr),
    .rise_o   (edge_ok)
  );

  evt_timer16_psc #(.PSC_W(PscW), .DIV_W(DIV_W)) u_psc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (ctrl_q.en),
    .src_ext_i (ctrl_q.src_ext),
    .edge_i    (edge_ok),
    .psc_i     (ctrl_q.psc),
    .clr_i     (cnt_wr),
    .inc_o     (inc),
    .pre_o     (pre)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(wdata_i[CtrlW-1:0]);
      // written byte wins; increment is dropped in that cycle
      if (lo_wr)       cnt_q[7:0]      <= wdata_i;
      else if (hi_wr)  cnt_q[CntW-1:8] <= wdata_i;
      else if (inc)    cnt_q           <= cnt_q + 1'b1;
      if (inc && !cnt_wr && (&cnt_q)) ovf_q <= 1'b1;
      else if (ovf_clr)               ovf_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (reg_addr_e'(addr_i))
      ADDR_CNT_LO: rdata_o = cnt_q[7:0];
      ADDR_CNT_HI: rdata_o = cnt_q[CntW-1:8];
      ADDR_CTRL: begin
        rdata_o[CtrlW-1:0] = ctrl_q;
        rdata_o[OvfBit]    = ovf_q;
      end
      default:     rdata_o = '0;
    endcase
  end

  assign ovf_o = ovf_q;
endmodule

// File: rtl/evt_timer16_chk.sv
module evt_timer16_chk #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             src_ext_i,
  input logic             cnt_wr_i,
  input logic             lo_wr_i,
  input logic [7:0]       wdata_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             inc_i,
  input logic             ovf_i,
  input logic             ovf_clr_i,
  input logic [PRE_W-1:0] pre_i
);
  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cnt_wr_i) |=> $stable(cnt_i));

  // R2
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_wr_i |=> (cnt_i == $past(cnt_i) || cnt_i == $past(cnt_i) + 1'b1));

  // R2
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !src_ext_i && inc_i) |=> !(inc_i && !src_ext_i));

  // R7
  pre_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> (pre_i == '0));

  // R8
  write_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_wr_i |=> (cnt_i[7:0] == $past(wdata_i)));

  // R9
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !cnt_wr_i && (&cnt_i)) |=> ovf_i);

  // R9
  ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && !ovf_clr_i) |=> ovf_i);

  // R9
  ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_i) |-> ($past(inc_i) && ($past(cnt_i) == '1)));
endmodule

bind evt_timer16 evt_timer16_chk #(.CNT_W(16), .PRE_W(3)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (ctrl_q.en),
  .src_ext_i (ctrl_q.src_ext),
  .cnt_wr_i  (cnt_wr),
  .lo_wr_i   (lo_wr),
  .wdata_i   (wdata_i),
  .cnt_i     (cnt_q),
  .inc_i     (inc),
  .ovf_i     (ovf_o),
  .ovf_clr_i (ovf_clr),
  .pre_i     (pre)
);

// File: tb/evt_timer16_test.sv
`timescale 1ns/1ps
module evt_timer16_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       ovf;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] a_v, b_v;

  always #4 clk = ~clk;

  evt_timer16 uut (
    .clk_i(clk), .rst_ni(rst_n), .ext_i(ext), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ovf_o(ovf)
  );

  // behavioural reference model
  int m_cnt, m_pre, m_div;
  bit m_armed, m_ovf, m_prev;
  bit [4:0] m_ctrl;
  bit hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_div = 0; m_armed = 0; m_ovf = 0;
      m_prev = 0; m_ctrl = 0; hist = '{0, 0};
    end else begin
      bit en, src, byp, sel, rise, fall, cw, tick, ev, inc;
      int div_by;
      en = m_ctrl[0]; src = m_ctrl[1]; byp = m_ctrl[4];
      div_by = 1 << m_ctrl[3:2];
      sel  = byp ? hist[$] : hist[$-1];
      rise = sel && !m_prev;
      fall = !sel && m_prev;
      cw   = we && (addr < 2);
      tick = (m_div % 4) == 3;
      ev   = en && (src ? (rise && m_armed) : tick);
      inc  = ev && ((m_pre % div_by) == div_by - 1);
      m_div = (m_div + 1) % 4;
      m_prev = sel;
      hist.push_back(ext);
      if (hist.size() > 4) void'(hist.pop_front());
      if (cw || !en) m_armed = 0; else if (fall) m_armed = 1;
      if (cw) m_pre = 0; else if (ev) m_pre = (m_pre + 1) % 8;
      if (inc && !cw && m_cnt == 65535) m_ovf = 1;
      else if (we && addr == 2 && !wdata[7]) m_ovf = 0;
      if (we && addr == 0)      m_cnt = (m_cnt & 32'hff00) | wdata;
      else if (we && addr == 1) m_cnt = (m_cnt & 32'h00ff) | (int'(wdata) << 8);
      else if (inc)             m_cnt = (m_cnt + 1) % 65536;
      if (we && addr == 2) m_ctrl = wdata[4:0];
    end
  end

  function automatic logic [7:0] model_byte(input logic [1:0] a);
    case (a)
      2'd0: return m_cnt[7:0];
      2'd1: return m_cnt[15:8];
      2'd2: return {m_ovf, 2'b00, m_ctrl};
      default: return 8'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R11 model read", rdata, model_byte(addr));
      chk("R9 model ovf", ovf, m_ovf);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #(8 * 200000);
    chk("watchdog", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, a_v); chk("R1 cnt lo", a_v, 0);
    rd(2'd1, a_v); chk("R1 cnt hi", a_v, 0);
    rd(2'd2, a_v); chk("R1 ctrl", a_v, 0);
    chk("R1 ovf", ovf, 0);

    // R2 quarter-rate timer
    wr(2'd2, 8'h01);
    rd(2'd0, a_v);
    repeat (40) @(posedge clk);
    rd(2'd0, b_v);
    chk("R2 ticks in 40 cycles", b_v - a_v, 10);

    // R3 prescaler ratios
    for (int k = 0; k < 4; k++) begin
      wr(2'd2, 8'h00); wr(2'd0, 8'h00); wr(2'd1, 8'h00);
      wr(2'd2, 8'(1 | (k << 2)));
      rd(2'd0, a_v);
      repeat (64) @(posedge clk);
      rd(2'd0, b_v);
      chk($sformatf("R3 psc code %0d", k), b_v - a_v, 16 >> k);
    end

    // R4 hold while disabled
    wr(2'd2, 8'h0c);
    rd(2'd0, a_v);
    repeat (20) @(posedge clk);
    rd(2'd0, b_v);
    chk("R4 hold", b_v, a_v);

    // R7 count write clears prescaler (divide by 8)
    wr(2'd2, 8'h0d);
    repeat (13) @(posedge clk);
    wr(2'd0, 8'h00);
    edges(28);
    chk("R7 psc cleared, 7 ticks", rdata, 0);
    edges(4);
    chk("R7 psc cleared, 8 ticks", rdata, 1);

    // R6 / R5 external counting, synchronised
    wr(2'd2, 8'h00); wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    @(negedge clk) ext = 1'b1;
    repeat (5) @(posedge clk);
    wr(2'd2, 8'h03);
    addr = 2'd0;
    edges(6);
    chk("R6 high at enable not counted", rdata, 0);
    @(negedge clk) ext = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) ext = 1'b1;
    edges(2);
    chk("R5 latency before edge k+2", rdata, 0);
    edges(1);
    chk("R5 counted at edge k+2", rdata, 1);
    for (int p = 0; p < 4; p++) begin
      @(negedge clk) ext = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk) ext = 1'b1;
      repeat (3) @(posedge clk);
    end
    edges(3);
    chk("R5 pulse count", rdata, 5);

    // R7 count write disarms
    @(negedge clk) ext = 1'b0;
    repeat (4) @(posedge clk);
    wr(2'd0, 8'h00);
    @(negedge clk) ext = 1'b1;
    edges(5);
    chk("R7 rise after write ignored", rdata, 0);
    @(negedge clk) ext = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) ext = 1'b1;
    edges(5);
    chk("R7 counted after fall", rdata, 1);

    // R10 bypass latency
    wr(2'd2, 8'h00);
    wr(2'd2, 8'h13);
    addr = 2'd0;
    @(negedge clk) ext = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) ext = 1'b1;
    edges(1);
    chk("R10 before edge k+1", rdata, 1);
    edges(1);
    chk("R10 counted at edge k+1", rdata, 2);
    @(negedge clk) ext = 1'b0;

    // R8 write wins over increment
    wr(2'd2, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h01);
    for (int i = 0; i < 4; i++) begin
      wr(2'd0, 8'h55);
      chk("R8 written byte wins", rdata, 8'h55);
    end

    // R11 byte reads and R9 overflow
    wr(2'd2, 8'h00); wr(2'd0, 8'hfe); wr(2'd1, 8'hff);
    rd(2'd0, a_v); chk("R11 lo byte", a_v, 8'hfe);
    rd(2'd1, a_v); chk("R11 hi byte", a_v, 8'hff);
    rd(2'd3, a_v); chk("R11 reserved", a_v, 0);
    wr(2'd2, 8'h01);
    repeat (12) @(posedge clk);
    rd(2'd2, a_v); chk("R9 flag in ctrl", a_v, 8'h81);
    chk("R9 ovf_o set", ovf, 1);
    rd(2'd1, a_v); chk("R9 wrapped hi", a_v, 0);
    repeat (10) @(posedge clk);
    chk("R9 sticky", ovf, 1);
    wr(2'd2, 8'h81);
    chk("R9 write 1 keeps", ovf, 1);
    wr(2'd2, 8'h01);
    chk("R9 write 0 clears", ovf, 0);

    repeat (4) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule